// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block counts ticks from one of two clock-enable inputs. It runs either as a periodic interval timer or as a system watchdog. The expiry period is one of four powers of two. A single 16-bit control register sets hold, counter clear, tick source, mode and period. Software writes that register over a plain register bus, and a write is accepted only when its upper byte carries an access key. Any write with a different upper byte is treated as a software fault and requests a system reset.

In interval mode, each expiry sets a sticky interrupt flag, which software clears through `irq_clr`, and counting starts again from zero. In watchdog mode, software must clear the counter before the period runs out. If it does not, the block raises a one-cycle reset request and returns its control register to the reset value. The register bus has no back-pressure. A write is taken in the cycle `bus_wr` is high, and `bus_rdata` always shows the register contents combinationally.

Top module: `pw_watchdog`

## Requirements
- R1: A control write is applied only when `bus_wdata[15:8]` equals 0x5A; any other key byte leaves every control field unchanged.
- R2: A write with a wrong key drives `rst_req` high in the following cycle, and the control register keeps its previous value.
- R3: `bus_rdata` returns 0x69 in bits 15:8, hold in bit 7, mode in bit 4, tick source in bit 2 and period code in bits 1:0. Bits 6, 5 and 3 read as 0, so the counter-clear bit is never seen set.
- R4: After reset, `bus_rdata` reads 0x6900. This means watchdog mode, period code 0, sub-main tick source and hold released.
- R5: While hold (bit 7) is 1, ticks do not advance the counter. Clearing hold resumes counting from the value held.
- R6: A keyed write with bit 3 set clears the counter to zero, so a full period must elapse before the next expiry.
- R7: Bit 2 = 0 counts `smclk_en` ticks and bit 2 = 1 counts `aclk_en` ticks. The source that is not selected has no effect.
- R8: Period codes 0, 1, 2 and 3 in bits 1:0 give expiry after 32768, 8192, 512 and 64 counted ticks. Expiry is the moment counter bit 15, 13, 9 or 6 rises.
- R9: With bit 4 = 1 (interval mode), expiry sets `irq_flag` in the following cycle. The flag stays set until `irq_clr` is driven high, and the next period is counted from zero.
- R10: With bit 4 = 0 (watchdog mode), expiry drives `rst_req` high for one cycle and leaves `irq_flag` untouched. The register reads 0x6900 from the following cycle on, and the counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smclk_en | input | 1 | Sub-main tick enable |
| aclk_en | input | 1 | Auxiliary tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data, key in 15:8 |
| bus_rdata | output | 16 | Register read value |
| irq_clr | input | 1 | Clears the interval flag |
| irq_flag | output | 1 | Sticky interval-expiry flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The period function is tried with random period codes and random tick sources. Both tick enables are toggled sparsely and at random, so an exact expiry on the Nth selected tick separates a correct tap choice from an off-by-one tap and from counting on the wrong source. Directed patterns cover the cases the random runs do not reach: hold with dense ticks, a mid-period counter clear in watchdog mode, a wrong key byte, and dense ticks on the unselected source. These show whether the freeze, the kick, the key check and the source isolation work.

// File: rtl/pwdt_pkg.sv
package pwdt_pkg;

  localparam int unsigned REG_W = 16;

  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_KEY = 8'h69;

  localparam int unsigned BIT_HOLD = 7;
  localparam int unsigned BIT_MODE = 4;
  localparam int unsigned BIT_CLR  = 3;
  localparam int unsigned BIT_SRC  = 2;

  typedef struct packed {
    logic       hold;
    logic       itv_mode;
    logic       src_aux;
    logic [1:0] isel;
  } pwdt_ctrl_t;

  localparam pwdt_ctrl_t CTRL_RST = '{hold: 1'b0, itv_mode: 1'b0, src_aux: 1'b0, isel: 2'd0};

endpackage

// File: rtl/pwdt_regif.sv
module pwdt_regif
  import pwdt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  wd_expire,
  output pwdt_ctrl_t            ctrl,
  output logic                  cnt_clr,
  output logic                  key_fail,
  output logic [REG_W-1:0]      rd_data
);

  logic key_ok;
  logic good_wr;
  logic unused_rsvd;
  pwdt_ctrl_t wr_fields;

  assign key_ok      = (wr_data[REG_W-1:8] == WR_KEY);
  assign good_wr     = wr_en && key_ok;
  assign key_fail    = wr_en && !key_ok;
  assign cnt_clr     = good_wr && wr_data[BIT_CLR];
  assign unused_rsvd = ^wr_data[6:5];

  always_comb begin
    wr_fields.hold     = wr_data[BIT_HOLD];
    wr_fields.itv_mode = wr_data[BIT_MODE];
    wr_fields.src_aux  = wr_data[BIT_SRC];
    wr_fields.isel     = wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl <= CTRL_RST;
    else if (wd_expire) ctrl <= CTRL_RST;
    else if (good_wr)   ctrl <= wr_fields;
  end

  always_comb begin
    rd_data              = '0;
    rd_data[REG_W-1:8]   = RD_KEY;
    rd_data[BIT_HOLD]    = ctrl.hold;
    rd_data[BIT_MODE]    = ctrl.itv_mode;
    rd_data[BIT_SRC]     = ctrl.src_aux;
    rd_data[1:0]         = ctrl.isel;
  end

  AST_BAD_KEY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_fail && !wd_expire) |=> (ctrl == $past(ctrl))); // R2

  AST_WD_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (ctrl == CTRL_RST)); // R10

endmodule

// File: rtl/pwdt_count.sv
module pwdt_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP0  = 15,
  parameter int unsigned TAP1  = 13,
  parameter int unsigned TAP2  = 9,
  parameter int unsigned TAP3  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  input  logic [1:0] isel,
  output logic       expire
);

  localparam int unsigned N_TAPS = 4;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_inc;
  logic [N_TAPS-1:0] tap_now;
  logic [N_TAPS-1:0] tap_nxt;

  assign cnt_inc = cnt + {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int unsigned POS = (i == 0) ? TAP0 : (i == 1) ? TAP1 : (i == 2) ? TAP2 : TAP3;
    assign tap_now[i] = cnt[POS];
    assign tap_nxt[i] = cnt_inc[POS];
  end

  assign expire = tick && !clr && tap_nxt[isel] && !tap_now[isel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || expire)   cnt <= '0;
    else if (tick)            cnt <= cnt_inc;
  end

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt)); // R5

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R6

endmodule

// File: rtl/pwdt_expiry.sv
module pwdt_expiry (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic itv_mode,
  input  logic key_fail,
  input  logic flag_clr,
  output logic irq_flag,
  output logic rst_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (expire && itv_mode) irq_flag <= 1'b1;
      else if (flag_clr)      irq_flag <= 1'b0;
      rst_req <= key_fail || (expire && !itv_mode);
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag); // R9

  AST_WD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !itv_mode) |=> (rst_req && $stable(irq_flag))); // R10

  AST_KEY_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    key_fail |=> rst_req); // R2

endmodule

// File: rtl/pw_watchdog.sv
module pw_watchdog
  import pwdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP0  = 15,
  parameter int unsigned TAP1  = 13,
  parameter int unsigned TAP2  = 9,
  parameter int unsigned TAP3  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smclk_en,
  input  logic             aclk_en,
  input  logic             bus_wr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             irq_clr,
  output logic             irq_flag,
  output logic             rst_req
);

  pwdt_ctrl_t ctrl;
  logic       cnt_clr;
  logic       key_fail;
  logic       expire;
  logic       wd_expire;
  logic       src_tick;
  logic       tick;

  assign src_tick  = ctrl.src_aux ? aclk_en : smclk_en;
  assign tick      = src_tick && !ctrl.hold;
  assign wd_expire = expire && !ctrl.itv_mode;

  pwdt_regif u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .wr_data   (bus_wdata),
    .wd_expire (wd_expire),
    .ctrl      (ctrl),
    .cnt_clr   (cnt_clr),
    .key_fail  (key_fail),
    .rd_data   (bus_rdata)
  );

  pwdt_count #(
    .CNT_W (CNT_W),
    .TAP0  (TAP0),
    .TAP1  (TAP1),
    .TAP2  (TAP2),
    .TAP3  (TAP3)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (cnt_clr),
    .isel   (ctrl.isel),
    .expire (expire)
  );

  pwdt_expiry u_expiry (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .itv_mode (ctrl.itv_mode),
    .key_fail (key_fail),
    .flag_clr (irq_clr),
    .irq_flag (irq_flag),
    .rst_req  (rst_req)
  );

  AST_HOLD_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.hold |-> !expire); // R5

endmodule

// File: tb/pw_watchdog_test.sv
module pw_watchdog_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smclk_en = 1'b0;
  logic        aclk_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_clr = 1'b0;
  logic        irq_flag;
  logic        rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pw_watchdog uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smclk_en  (smclk_en),
    .aclk_en   (aclk_en),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_clr   (irq_clr),
    .irq_flag  (irq_flag),
    .rst_req   (rst_req)
  );

  function automatic int period_of(input logic [1:0] code);
    case (code)
      2'd0: return 32768;
      2'd1: return 8192;
      2'd2: return 512;
      default: return 64;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] w);
    bus_wr = 1'b1;
    bus_wdata = w;
    step();
    bus_wr = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
  endtask

  // tick the aux enable n times, one per cycle
  task automatic aux_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      aclk_en = 1'b1;
      step();
    end
    aclk_en = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    chk("R4 rdata", bus_rdata, 16'h6900);
    chk("R4 irq", irq_flag, 1'b0);
    chk("R4 rst_req", rst_req, 1'b0);

    // R1/R3: keyed write, clear bit reads 0
    wr(16'h5A9D);
    chk("R1 keyed write applied", bus_rdata, 16'h6995);
    chk("R3 reserved bits read 0", bus_rdata[6:5], 2'b00);
    chk("R3 clear bit reads 0", bus_rdata[3], 1'b0);

    // R2 wrong key
    wr(16'hA513);
    chk("R2 rst_req after bad key", rst_req, 1'b1);
    chk("R2 register kept", bus_rdata, 16'h6995);
    step();
    chk("R2 rst_req one cycle", rst_req, 1'b0);
    wr(16'h5B00);
    chk("R1 near-miss key ignored", bus_rdata, 16'h6995);
    step();

    // R5 hold: interval, aux, code 3, held
    wr(16'h5A9F);
    aux_ticks(200);
    chk("R5 no expiry while held", irq_flag, 1'b0);
    wr(16'h5A17);
    aux_ticks(63);
    chk("R8 code3 not before 64", irq_flag, 1'b0);
    aux_ticks(1);
    chk("R8 code3 at 64", irq_flag, 1'b1);

    // R9 sticky then clear, restart from zero
    repeat (10) step();
    chk("R9 flag sticky", irq_flag, 1'b1);
    pulse_clr();
    chk("R9 flag cleared", irq_flag, 1'b0);
    aux_ticks(63);
    chk("R9 restart not before 64", irq_flag, 1'b0);
    aux_ticks(1);
    chk("R9 restart at 64", irq_flag, 1'b1);
    pulse_clr();

    // R7 unselected source ignored
    smclk_en = 1'b1;
    repeat (100) step();
    smclk_en = 1'b0;
    chk("R7 smclk ignored under aux", irq_flag, 1'b0);

    // R8 code 0 dense on sub-main
    wr(16'h5A18);
    smclk_en = 1'b1;
    repeat (32767) step();
    chk("R8 code0 not before 32768", irq_flag, 1'b0);
    step();
    smclk_en = 1'b0;
    chk("R8 code0 at 32768", irq_flag, 1'b1);
    pulse_clr();

    // R7/R8 random trials
    for (int t = 0; t < 6; t++) begin
      logic [1:0] code;
      logic       src;
      int         per;
      int         cnt;
      code = 2'(1 + ($urandom % 3));
      src  = 1'($urandom % 2);
      per  = period_of(code);
      cnt  = 0;
      irq_clr = 1'b1;
      wr({8'h5A, 3'b000, 1'b1, 1'b1, src, code});
      irq_clr = 1'b0;
      while (cnt < per) begin
        logic sel;
        sel = ($urandom % 4) != 0;
        if (src) begin aclk_en = sel; smclk_en = 1'($urandom % 2); end
        else     begin smclk_en = sel; aclk_en = 1'($urandom % 2); end
        step();
        if (sel) begin
          cnt++;
          if (cnt == per - 1) chk("R8 random period early", irq_flag, 1'b0);
          if (cnt == per)     chk("R7 random period exact", irq_flag, 1'b1);
        end
      end
      aclk_en = 1'b0;
      smclk_en = 1'b0;
    end
    pulse_clr();

    // R6/R10 watchdog kick and expiry
    wr(16'h5A0F);
    aux_ticks(50);
    wr(16'h5A0F);
    begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 63; k++) begin
        aclk_en = 1'b1;
        step();
        if (rst_req) seen = 1'b1;
      end
      chk("R6 kick restarted period", seen, 1'b0);
    end
    aux_ticks(1);
    chk("R10 rst_req on expiry", rst_req, 1'b1);
    chk("R10 register restored", bus_rdata, 16'h6900);
    chk("R10 no irq in watchdog", irq_flag, 1'b0);
    step();
    chk("R10 rst_req one cycle", rst_req, 1'b0);

    done = 1'b1;
    summary();
  end

endmodule